// File: doc/BRIEF.md
# PWM Interrupt Combiner

This block gathers the interrupt requests of a pulse-width modulation unit into one request line for the interrupt controller. Three generator sub-blocks each present a level request, and one external fault pin can also raise a request. Software sees three word-wide registers on a small register bus: an enable register, a raw view of every source whether or not it is enabled, and a masked view that also clears the fault when written.

The two kinds of source behave differently. A generator request is a live level that follows its generator; it is cleared inside that generator and cannot be cleared here. The fault pin passes through a synchronizer. A rising edge of the synchronized pin sets a sticky flag, and only a write-one from software clears that flag. If a new fault edge and a clear arrive in the same cycle, the fault stays set. A pin that stays high after a clear does not set the flag again until it has gone low and risen once more.

Top module: `pwm_irq_hub`

## Requirements
- R1: After reset the enable register, the raw register and the masked register all read 0, and `irq_out` is 0.
- R2: The enable register sits at offset 0x14. It is writable at bit 16 (fault) and bits 2:0 (generator 2..0). Every other bit reads 0 whatever was written.
- R3: The raw register at offset 0x18 shows generator i's request level at bit i (i = 0..2) in the same cycle, whatever the enable register holds.
- R4: A rising edge on `fault_in` sets raw bit 16 three clock edges later. The delay is two synchronizer stages plus the edge register. The bit stays set after `fault_in` falls.
- R5: The masked register at offset 0x1C reads the raw register ANDed with the enable register.
- R6: `irq_out` is 1 exactly when some bit of the masked register is 1. It follows a generator level in the same cycle.
- R7: Writing 1 to bit 16 of offset 0x1C clears the fault flag. Writing bits 2:0 of offset 0x1C has no effect, and any write to offset 0x18 has no effect.
- R8: If a fault edge is detected in the same cycle as a clear write, the fault flag stays set.
- R9: A fault pin that is still high after a clear does not set the flag again. A fall followed by a new rise sets it.
- R10: Offsets other than 0x14, 0x18 and 0x1C read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| fault_in | input | 1 | Asynchronous fault pin, active high |
| gen_irq | input | 3 | Level requests from generators 2..0 |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_out | output | 1 | Combined interrupt to the controller |

## Verification
A corrupted enable bit shows on the very next read of offset 0x14 or 0x1C. It also shows on `irq_out` in the same cycle that the matching source is active. A fault flag that is wrongly set or wrongly cleared stays in that wrong state until software writes it, so it shows on reads of 0x18 and on `irq_out` until then. The bench therefore checks the fault flag at exactly three edges after a pin rise, and again right after clears that collide with a new edge. A generator bit that is wrongly latched, rather than passed through, shows as soon as that generator's level drops.

// File: rtl/pwm_irq_pkg.sv
package pwm_irq_pkg;
   localparam int unsigned GEN_COUNT = 3;
   localparam int unsigned FAULT_POS = 16;
   localparam int unsigned BUS_AW    = 8;
   localparam int unsigned BUS_DW    = 32;
   localparam int unsigned SYNC_LEN  = 2;

   localparam logic [7:0] OFS_ENABLE = 8'h14;
   localparam logic [7:0] OFS_RAW    = 8'h18;
   localparam logic [7:0] OFS_MASKED = 8'h1C;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_ENABLE,
      SEL_RAW,
      SEL_MASKED
   } reg_sel_e;
endpackage

// File: rtl/pwm_irq_fault_catch.sv
module pwm_irq_fault_catch #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_in,
   input  logic clear_req,
   output logic fault_flag
);
   localparam int unsigned TOP = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pwm_irq_fault_catch: SYNC_STAGES must be at least 2");
   end

   logic [TOP:0] chain_q;
   logic         prev_q;
   logic         detect;
   logic         flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[TOP-1:0], fault_in};
         prev_q  <= chain_q[TOP];
      end
   end

   assign detect = chain_q[TOP] & ~prev_q;

   // A new detection outranks a clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (detect)     flag_q <= 1'b1;
      else if (clear_req)  flag_q <= 1'b0;
   end

   assign fault_flag = flag_q;

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (detect && clear_req) |=> fault_flag);

   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_req && !detect) |=> !fault_flag);

   assert_edge_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_flag && !detect) |=> !fault_flag);

   assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_flag && !clear_req) |=> fault_flag);
endmodule

// File: rtl/pwm_irq_combine.sv
module pwm_irq_combine #(
   parameter int unsigned NUM_GEN   = 3,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned FAULT_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_GEN-1:0] gen_irq,
   input  logic              fault_flag,
   input  logic [DATA_W-1:0] enable_vec,
   output logic [DATA_W-1:0] raw_vec,
   output logic [DATA_W-1:0] masked_vec,
   output logic              irq_out
);
   if (FAULT_BIT < NUM_GEN || FAULT_BIT >= DATA_W) begin : g_bad_layout
      $error("pwm_irq_combine: fault bit overlaps generators or exceeds width");
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b < NUM_GEN) begin : g_gen
         assign raw_vec[b] = gen_irq[b];
      end else if (b == FAULT_BIT) begin : g_flt
         assign raw_vec[b] = fault_flag;
      end else begin : g_rsv
         assign raw_vec[b] = 1'b0;
      end
   end

   assign masked_vec = raw_vec & enable_vec;
   assign irq_out    = |masked_vec;

   assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_vec == '0) |-> !irq_out);

   assert_fault_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_flag && enable_vec[FAULT_BIT]) |-> irq_out);
endmodule

// File: rtl/pwm_irq_regs.sv
module pwm_irq_regs
   import pwm_irq_pkg::*;
#(
   parameter int unsigned NUM_GEN   = 3,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned FAULT_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] raw_vec,
   input  logic [DATA_W-1:0] masked_vec,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] enable_vec,
   output logic              clear_req
);
   localparam logic [DATA_W-1:0] EN_MASK =
      (DATA_W'(1) << FAULT_BIT) | ((DATA_W'(1) << NUM_GEN) - DATA_W'(1));

   if (ADDR_W < 5) begin : g_bad_addr
      $error("pwm_irq_regs: ADDR_W too small for the register offsets");
   end

   reg_sel_e          sel;
   logic [DATA_W-1:0] en_q;

   always_comb begin
      if      (bus_addr == ADDR_W'(OFS_ENABLE)) sel = SEL_ENABLE;
      else if (bus_addr == ADDR_W'(OFS_RAW))    sel = SEL_RAW;
      else if (bus_addr == ADDR_W'(OFS_MASKED)) sel = SEL_MASKED;
      else                                      sel = SEL_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= '0;
      else if (bus_sel && bus_wr && sel == SEL_ENABLE)
         en_q <= bus_wdata & EN_MASK;
   end

   assign clear_req  = bus_sel && bus_wr && (sel == SEL_MASKED) && bus_wdata[FAULT_BIT];
   assign enable_vec = en_q;

   always_comb begin
      unique case (sel)
         SEL_ENABLE: bus_rdata = en_q;
         SEL_RAW:    bus_rdata = raw_vec;
         SEL_MASKED: bus_rdata = masked_vec;
         default:    bus_rdata = '0;
      endcase
   end

   assert_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata & ~EN_MASK) == '0);

   assert_enable_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr && sel == SEL_ENABLE) |=> $stable(en_q));
endmodule

// File: rtl/pwm_irq_hub.sv
module pwm_irq_hub
   import pwm_irq_pkg::*;
#(
   parameter int unsigned NUM_GEN     = GEN_COUNT,
   parameter int unsigned ADDR_W      = BUS_AW,
   parameter int unsigned DATA_W      = BUS_DW,
   parameter int unsigned FAULT_BIT   = FAULT_POS,
   parameter int unsigned SYNC_STAGES = SYNC_LEN
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fault_in,
   input  logic [NUM_GEN-1:0] gen_irq,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_out
);
   logic              fault_flag;
   logic              clear_req;
   logic [DATA_W-1:0] enable_vec;
   logic [DATA_W-1:0] raw_vec;
   logic [DATA_W-1:0] masked_vec;

   pwm_irq_fault_catch #(.SYNC_STAGES(SYNC_STAGES)) u_fault (
      .clk        (clk),
      .rst_n      (rst_n),
      .fault_in   (fault_in),
      .clear_req  (clear_req),
      .fault_flag (fault_flag)
   );

   pwm_irq_combine #(.NUM_GEN(NUM_GEN), .DATA_W(DATA_W), .FAULT_BIT(FAULT_BIT)) u_comb (
      .clk        (clk),
      .rst_n      (rst_n),
      .gen_irq    (gen_irq),
      .fault_flag (fault_flag),
      .enable_vec (enable_vec),
      .raw_vec    (raw_vec),
      .masked_vec (masked_vec),
      .irq_out    (irq_out)
   );

   pwm_irq_regs #(.NUM_GEN(NUM_GEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .FAULT_BIT(FAULT_BIT)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .raw_vec    (raw_vec),
      .masked_vec (masked_vec),
      .bus_rdata  (bus_rdata),
      .enable_vec (enable_vec),
      .clear_req  (clear_req)
   );
endmodule

// File: tb/sim_pwm_irq_hub.sv
`timescale 1ns/1ps
module sim_pwm_irq_hub;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fault_in = 1'b0;
   logic [2:0]  gen_irq = '0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   pwm_irq_hub u0 (
      .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .gen_irq(gen_irq),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   function automatic logic [31:0] f_raw(input logic [2:0] g, input logic f);
      return {15'd0, f, 13'd0, g};
   endfunction

   function automatic logic [31:0] f_en(input logic [31:0] w);
      return w & 32'h0001_0007;
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #0.5 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] en_m;
      void'($urandom(32'd7531));
      wait_neg(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h14, v); check("R1 enable", v, 32'h0);
      rd(8'h18, v); check("R1 raw", v, 32'h0);
      rd(8'h1C, v); check("R1 masked", v, 32'h0);
      check("R1 irq", {31'd0, irq_out}, 32'h0);

      // R2 enable write with reserved bits
      wr(8'h14, 32'hFFFF_FFFF);
      rd(8'h14, v); check("R2 enable mask", v, 32'h0001_0007);
      wr(8'h14, 32'h0);

      // R3 raw live, R6 quiet with enable clear
      gen_irq = 3'b101;
      rd(8'h18, v); check("R3 raw live", v, f_raw(3'b101, 1'b0));
      check("R6 no enable", {31'd0, irq_out}, 32'h0);

      // R4 fault latency: drive at negedge, latched after third edge
      gen_irq = '0;
      fault_in = 1'b1;
      wait_neg(2);
      rd(8'h18, v); check("R4 not yet", v, 32'h0);
      @(negedge clk);
      rd(8'h18, v); check("R4 latched", v, f_raw(3'b000, 1'b1));
      fault_in = 1'b0;
      wait_neg(4);
      rd(8'h18, v); check("R4 sticky", v, f_raw(3'b000, 1'b1));

      // R7 writes to raw and generator clear bits ignored
      gen_irq = 3'b011;
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h1C, 32'h0000_0007);
      rd(8'h18, v); check("R7 ignored", v, f_raw(3'b011, 1'b1));

      // R10 unmapped offsets
      wr(8'h20, 32'hFFFF_FFFF);
      wr(8'h10, 32'hFFFF_FFFF);
      rd(8'h20, v); check("R10 read zero", v, 32'h0);
      rd(8'h14, v); check("R10 enable untouched", v, 32'h0);

      // R7 clear fault
      wr(8'h1C, 32'h0001_0000);
      rd(8'h18, v); check("R7 cleared", v, f_raw(3'b011, 1'b0));

      // R8 set wins: latch, drop, rise again with clear on detection edge
      gen_irq = '0;
      fault_in = 1'b1; wait_neg(4); fault_in = 1'b0; wait_neg(4);
      rd(8'h18, v); check("R8 pre set", v, f_raw(3'b000, 1'b1));
      fault_in = 1'b1;
      wait_neg(2);
      wr(8'h1C, 32'h0001_0000);
      rd(8'h18, v); check("R8 set wins", v, f_raw(3'b000, 1'b1));

      // R9 held pin does not re-latch after clear
      wait_neg(2);
      wr(8'h1C, 32'h0001_0000);
      wait_neg(6);
      rd(8'h18, v); check("R9 no relatch", v, 32'h0);
      fault_in = 1'b0; wait_neg(3);
      fault_in = 1'b1; wait_neg(3);
      rd(8'h18, v); check("R9 new rise", v, f_raw(3'b000, 1'b1));
      fault_in = 1'b0;

      // R5/R6 fault masked path
      wr(8'h14, 32'h0001_0000);
      rd(8'h1C, v); check("R5 fault masked", v, 32'h0001_0000);
      check("R6 fault irq", {31'd0, irq_out}, 32'h1);
      wr(8'h1C, 32'h0001_0000);
      check("R6 after clear", {31'd0, irq_out}, 32'h0);

      // R3/R5/R6 random generator levels and enables, fault flag clear
      for (int k = 0; k < 200; k++) begin
         en_m = f_en($urandom());
         wr(8'h14, en_m | ($urandom() & 32'hFFFE_FFF8));
         gen_irq = 3'($urandom());
         rd(8'h18, v); check("R3 random raw", v, f_raw(gen_irq, 1'b0));
         rd(8'h1C, v); check("R5 random masked", v, f_raw(gen_irq, 1'b0) & en_m);
         check("R6 random irq", {31'd0, irq_out},
               {31'd0, |(f_raw(gen_irq, 1'b0) & en_m)});
         @(negedge clk);
      end

      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule